// File: doc/BRIEF.md
# Clock Configuration Serial Write Slave

This block is a write-only slave on a two-wire serial bus (SMBus style block write). It sits next to a clock generator and holds six byte-wide configuration registers. These registers gate individual clock outputs and select the spread-spectrum behaviour. The block oversamples SCL and SDA with its own system clock, finds START and STOP conditions, and checks the device address. It acknowledges each accepted byte by pulling SDA low during the ninth SCL pulse.

After the address, a transfer carries a command byte and a count byte. Both are acknowledged and thrown away. Every byte after them goes into the registers in order, beginning with register 0. The registers appear as one flat bus, and their meaningful bits are also broken out as named enable and spread-control outputs. A power-on reset is the only thing that restores the defaults.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: While `rst` is high at a clock edge, the registers take their defaults on the next edge: register 0 = 0x07, register 1 = 0xFF, register 2 = 0xFE, registers 3, 4 and 5 = 0x00. Register k sits at `regs_o[8k+7:8k]`.
- R2: The first byte after a START is the address byte, sent as {address[6:0], rw}. Only address 0x69 with rw = 0 (byte 0xD2) is acknowledged. Any other address byte gets no acknowledge, and the slave then acknowledges nothing and writes nothing until the next START.
- R3: The two bytes after an accepted address are the command byte and the count byte. Each is acknowledged, and neither value changes any register.
- R4: The data bytes that follow go to register 0, 1, 2 and onward, one register per byte, and each is acknowledged.
- R5: Data bytes past the sixth are acknowledged and discarded.
- R6: A STOP or a repeated START ends a transfer at any point. Registers not yet written keep their values, and neither a START nor a STOP restores the defaults.
- R7: Reserved bits always read 0, whatever is written to them. The writable bits are register 0 bits 3:0, all of register 1, register 2 bits 7:1, and register 5 bits 7:5. Registers 3 and 4 have no writable bits.
- R8: The named outputs decode as follows: `sdram_en` = register 1; `pci_en` = register 2 bits 7:1; `dot_en`, `usb_en` and `cpu_itp_en` = register 0 bits 2, 1 and 0; `ss_on` = register 0 bit 3; `ss_center` = register 5 bit 7 (0 selects down-spread, 1 selects center-spread); `ss_amount` = register 5 bits 6:5. For every enable, 1 turns the clock on.
- R9: `sda_oe` pulls SDA low only for the acknowledge, from the SCL fall after the eighth bit to the SCL fall after the ninth. It changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| regs_o | output | 48 | All six registers, register k at bits 8k+7:8k |
| sdram_en | output | 8 | Memory clock enables |
| pci_en | output | 7 | Peripheral clock enables |
| cpu_itp_en | output | 1 | Processor/debug clock enable |
| usb_en | output | 1 | USB clock enable |
| dot_en | output | 1 | Display clock enable |
| ss_on | output | 1 | Spread spectrum enable |
| ss_center | output | 1 | Spread mode: 0 down, 1 center |
| ss_amount | output | 2 | Spread amount code |

## Verification
The write path is driven with random data, random command and count values, and random lengths from zero to eight data bytes. This shows whether bytes land in sequence from register 0, whether the two leading bytes are really ignored, and whether bytes past the sixth are dropped. Directed cases cover the following:
- a wrong address and a read request, which must stay silent even when a valid-looking address follows inside the same transfer;
- a repeated START in the middle of a transfer, which must leave the unwritten registers as they were;
- all-ones data, which exposes any reserved bit that leaks through;
- a reset pulse at the end, which must be the only way the defaults return.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int REG_COUNT  = 6;
    localparam int BYTE_W     = 8;
    localparam int SKIP_BYTES = 2;   // command and count bytes after the address

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_RECV,
        LS_ACK,
        LS_IGNORE
    } link_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic                    en;
        logic [$clog2(REG_COUNT)-1:0] idx;
        logic [BYTE_W-1:0]       data;
    } reg_wr_t;

    function automatic logic [BYTE_W-1:0] reg_default(int idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'hFF;
            2:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reg_writable(int idx);
        case (idx)
            0:       return 8'h0F;
            1:       return 8'hFF;
            2:       return 8'hFE;
            5:       return 8'hE0;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler
    import clkcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_pipe;
    logic [MSB:0] sda_pipe;
    logic         scl_d;
    logic         sda_d;
    logic         scl_now;
    logic         sda_now;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
                    sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_now;
            sda_d <= sda_now;
        end
    end

    assign scl_now = scl_pipe[MSB];
    assign sda_now = sda_pipe[MSB];

    always_comb begin
        evt.start = scl_now & scl_d & sda_d & ~sda_now;
        evt.stop  = scl_now & scl_d & ~sda_d & sda_now;
        evt.rise  = scl_now & ~scl_d;
        evt.fall  = ~scl_now & scl_d;
        evt.sda   = sda_now;
    end

endmodule

// File: rtl/byte_link.sv
module byte_link
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREG     = REG_COUNT
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    output logic     sda_oe,
    output reg_wr_t  wr
);
    localparam int FIRST_DATA = SKIP_BYTES + 1;
    localparam int POS_MAX    = FIRST_DATA + NREG;
    localparam int POS_W      = $clog2(POS_MAX + 1);
    localparam int IDX_W      = $clog2(REG_COUNT);

    link_state_e       state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [POS_W-1:0]  pos;

    logic             addr_ok;
    logic             accept;
    logic             is_data;
    logic [POS_W-1:0] slot;

    always_comb begin
        addr_ok = (shreg[7:1] == DEV_ADDR) && (shreg[0] == 1'b0);
        accept  = (pos != '0) || addr_ok;
        is_data = (pos >= POS_W'(FIRST_DATA)) && (pos < POS_W'(POS_MAX));
        slot    = pos - POS_W'(FIRST_DATA);
    end

    always_ff @(posedge clk) begin
        wr.en <= 1'b0;
        if (rst) begin
            state   <= LS_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            pos     <= '0;
            sda_oe  <= 1'b0;
            wr.idx  <= '0;
            wr.data <= '0;
        end else if (evt.start) begin
            state  <= LS_RECV;
            bitcnt <= '0;
            pos    <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state  <= LS_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                LS_RECV: begin
                    if (evt.rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], evt.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (evt.fall && bitcnt == 4'd8) begin
                        if (accept) begin
                            state  <= LS_ACK;
                            sda_oe <= 1'b1;
                            if (is_data) begin
                                wr.en   <= 1'b1;
                                wr.idx  <= slot[IDX_W-1:0];
                                wr.data <= shreg;
                            end
                        end else begin
                            state <= LS_IGNORE;
                        end
                    end
                end
                LS_ACK: begin
                    if (evt.fall) begin
                        sda_oe <= 1'b0;
                        state  <= LS_RECV;
                        bitcnt <= '0;
                        if (pos != POS_W'(POS_MAX)) pos <= pos + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import clkcfg_pkg::*;
#(
    parameter int NREG = REG_COUNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  reg_wr_t                  wr,
    output logic [NREG*BYTE_W-1:0]   regs
);
    localparam int IDX_W = $clog2(REG_COUNT);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] DEF  = reg_default(g);
        localparam logic [BYTE_W-1:0] MASK = reg_writable(g);
        logic [BYTE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= DEF;
            end else if (wr.en && wr.idx == IDX_W'(g)) begin
                q <= wr.data & MASK;
            end
        end

        assign regs[g*BYTE_W +: BYTE_W] = q;
    end

endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NREG        = REG_COUNT,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic [7:0]             sdram_en,
    output logic [6:0]             pci_en,
    output logic                   cpu_itp_en,
    output logic                   usb_en,
    output logic                   dot_en,
    output logic                   ss_on,
    output logic                   ss_center,
    output logic [1:0]             ss_amount
);
    bus_evt_t evt;
    reg_wr_t  wr;

    bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    byte_link #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) i_link (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .sda_oe (sda_oe),
        .wr     (wr)
    );

    cfg_bank #(.NREG(NREG)) i_bank (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .regs (regs_o)
    );

    // named views of the stored bytes
    assign cpu_itp_en = regs_o[0];
    assign usb_en     = regs_o[1];
    assign dot_en     = regs_o[2];
    assign ss_on      = regs_o[3];
    assign sdram_en   = regs_o[15:8];
    assign pci_en     = regs_o[23:17];
    assign ss_amount  = regs_o[46:45];
    assign ss_center  = regs_o[47];

endmodule

// File: rtl/clkcfg_smb_slave_chk.sv
module clkcfg_smb_slave_chk
    import clkcfg_pkg::*;
#(
    parameter int NREG = REG_COUNT
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_i,
    input logic                   sda_oe,
    input logic [NREG*BYTE_W-1:0] regs_o
);
    function automatic logic [NREG*BYTE_W-1:0] pack_defaults();
        logic [NREG*BYTE_W-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*BYTE_W +: BYTE_W] = reg_default(i);
        return v;
    endfunction

    function automatic logic [NREG*BYTE_W-1:0] pack_masks();
        logic [NREG*BYTE_W-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*BYTE_W +: BYTE_W] = reg_writable(i);
        return v;
    endfunction

    localparam logic [NREG*BYTE_W-1:0] DEF_FLAT  = pack_defaults();
    localparam logic [NREG*BYTE_W-1:0] MASK_FLAT = pack_masks();

    assert_defaults_R1: assert property (@(posedge clk)
        rst |=> (regs_o == DEF_FLAT));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ((regs_o & ~MASK_FLAT) == '0));

    assert_ack_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (sda_oe != $past(sda_oe))) |-> !scl_i);

    assert_write_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (regs_o != $past(regs_o))) |-> !scl_i);

endmodule

bind clkcfg_smb_slave clkcfg_smb_slave_chk #(.NREG(NREG)) i_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .regs_o (regs_o)
);

// File: tb/test_clkcfg_smb_slave.sv
module test_clkcfg_smb_slave;
    localparam int NREG = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        scl_m;
    logic        sda_m;
    logic        sda_line;
    logic        sda_oe;
    logic [47:0] regs_o;
    logic [7:0]  sdram_en;
    logic [6:0]  pci_en;
    logic        cpu_itp_en, usb_en, dot_en, ss_on, ss_center;
    logic [1:0]  ss_amount;

    assign sda_line = sda_m & ~sda_oe;

    clkcfg_smb_slave i_clkcfg_smb_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .regs_o(regs_o), .sdram_en(sdram_en), .pci_en(pci_en),
        .cpu_itp_en(cpu_itp_en), .usb_en(usb_en), .dot_en(dot_en),
        .ss_on(ss_on), .ss_center(ss_center), .ss_amount(ss_amount)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [7:0] model   [NREG];
    logic [7:0] payload [10];

    function automatic logic [7:0] def_of(int i);
        case (i) 0: return 8'h07; 1: return 8'hFF; 2: return 8'hFE; default: return 8'h00; endcase
    endfunction

    function automatic logic [7:0] mask_of(int i);
        case (i) 0: return 8'h0F; 1: return 8'hFF; 2: return 8'hFE; 5: return 8'hE0; default: return 8'h00; endcase
    endfunction

    function automatic logic [47:0] model_flat();
        logic [47:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    function automatic logic [21:0] decode_exp();
        return {model[1], model[2][7:1], model[0][0], model[0][1], model[0][2],
                model[0][3], model[5][7], model[5][6:5]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; bus_wait(4);
        scl_m = 1'b1; bus_wait(8);
        sda_m = 1'b0; bus_wait(8);
        scl_m = 1'b0; bus_wait(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; bus_wait(4);
        scl_m = 1'b1; bus_wait(8);
        sda_m = 1'b1; bus_wait(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; bus_wait(4);
            scl_m = 1'b1; bus_wait(8);
            scl_m = 1'b0; bus_wait(4);
        end
        sda_m = 1'b1; bus_wait(4);
        scl_m = 1'b1; bus_wait(4);
        acked = (sda_line == 1'b0);
        bus_wait(4);
        scl_m = 1'b0; bus_wait(4);
    endtask

    task automatic check_regs(input string tag);
        bus_wait(4);
        check(tag, {16'h0, regs_o}, {16'h0, model_flat()});
        check("R8 decode", {42'h0, sdram_en, pci_en, cpu_itp_en, usb_en, dot_en,
                            ss_on, ss_center, ss_amount}, {42'h0, decode_exp()});
    endtask

    // full transfer: address, command, count, ndata payload bytes, then STOP
    task automatic do_write(input logic [7:0] addr_byte, input int ndata, input bit exp_ack);
        bit a;
        bus_start();
        send_byte(addr_byte, a);
        check(exp_ack ? "R2 address ack" : "R2 address nack", {63'h0, a}, {63'h0, exp_ack});
        send_byte(8'($urandom), a);
        check(exp_ack ? "R3 command ack" : "R2 ignored after nack", {63'h0, a}, {63'h0, exp_ack});
        send_byte(8'($urandom), a);
        check(exp_ack ? "R3 count ack" : "R2 ignored after nack", {63'h0, a}, {63'h0, exp_ack});
        for (int k = 0; k < ndata; k++) begin
            send_byte(payload[k], a);
            check(k < NREG ? "R4 data ack" : "R5 extra ack", {63'h0, a}, {63'h0, exp_ack});
            if (exp_ack && k < NREG) model[k] = payload[k] & mask_of(k);
        end
        check("R9 released after ack", {63'h0, sda_oe}, 64'h0);
        bus_stop();
    endtask

    initial begin
        bit a;
        void'($urandom(32'd20240611));
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
        bus_wait(5);
        for (int i = 0; i < NREG; i++) model[i] = def_of(i);
        check_regs("R1 reset defaults");
        rst = 1'b0;
        bus_wait(10);
        check_regs("R1 defaults after release");

        // directed: all ones shows reserved masking
        for (int k = 0; k < NREG; k++) payload[k] = 8'hFF;
        do_write(8'hD2, NREG, 1'b1);
        check_regs("R7 reserved bits zero");

        // directed: full random write of six bytes
        for (int k = 0; k < NREG; k++) payload[k] = 8'($urandom);
        do_write(8'hD2, NREG, 1'b1);
        check_regs("R4 six bytes in order");

        // wrong address, then a valid-looking address byte in the same transfer
        for (int k = 0; k < NREG; k++) payload[k] = 8'hD2;
        do_write(8'hA4, 3, 1'b0);
        check_regs("R2 wrong address leaves registers");

        // read request
        do_write(8'hD3, 2, 1'b0);
        check_regs("R2 read request ignored");

        // partial write: two bytes, others keep value across START/STOP
        payload[0] = 8'h05; payload[1] = 8'h3C;
        do_write(8'hD2, 2, 1'b1);
        check_regs("R6 partial write keeps rest");

        // extra bytes beyond register 5
        for (int k = 0; k < 8; k++) payload[k] = 8'($urandom);
        do_write(8'hD2, 8, 1'b1);
        check_regs("R5 extra bytes discarded");

        // repeated START after one data byte, then a new transfer
        bus_start();
        send_byte(8'hD2, a); check("R2 address ack", {63'h0, a}, 64'h1);
        send_byte(8'h11, a); check("R3 command ack", {63'h0, a}, 64'h1);
        send_byte(8'h22, a); check("R3 count ack", {63'h0, a}, 64'h1);
        send_byte(8'h0A, a); check("R4 data ack", {63'h0, a}, 64'h1);
        model[0] = 8'h0A & mask_of(0);
        bus_start();
        send_byte(8'hD2, a); check("R6 repeated start address ack", {63'h0, a}, 64'h1);
        send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h81, a); check("R6 restart data ack", {63'h0, a}, 64'h1);
        model[0] = 8'h81 & mask_of(0);
        bus_stop();
        check_regs("R6 repeated start restarts at register 0");

        // random transfers of random length
        for (int t = 0; t < 20; t++) begin
            int n;
            n = int'($urandom_range(0, 8));
            for (int k = 0; k < 10; k++) payload[k] = 8'($urandom);
            do_write(8'hD2, n, 1'b1);
            check_regs("R4 random write");
        end

        // power-on reset is the only way back to defaults
        @(negedge clk); rst = 1'b1;
        bus_wait(2);
        rst = 1'b0;
        for (int i = 0; i < NREG; i++) model[i] = def_of(i);
        check_regs("R1 defaults after power-on reset");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule